// File: doc/BRIEF.md
# Rename-Stage Result Reuse Table

This block is a set-associative table that lets the rename stage of an out-of-order core reuse results that a speculative helper thread has already computed. The helper side writes entries: an instruction PC, the physical register tags its sources were read from, and the physical register tag its result went to. The rename stage queries the table with an instruction PC and the physical tags its sources are currently mapped to. When both the PC and every source tag agree with a stored entry, the block hands back the stored destination tag. Rename then points the destination's map entry at that tag instead of allocating a fresh register. Nothing is read from or written to the register file. Because the returned tag becomes the new mapping, a dependent instruction's sources can match the next entry, so reuse follows whole dependence chains.

The block also manages helper-owned registers. When a fill displaces a live entry, that entry's destination tag goes out on a free stream. Every stored entry that read that tag is dropped in the same cycle. The block also keeps a short list of load PCs whose reuse later led to a squash, and it refuses reuse to loads at those PCs.

The lookup request stream is always ready, and each accepted request produces exactly one response one cycle later. The response has no back-pressure, because rename consumes it at once. The fill stream is held off while a lookup is presented and while a freed tag waits on a stalled free stream. The free stream holds its tag until the consumer accepts it.

Top module: `reuse_table`

## Requirements
- R1: A lookup accepted in cycle t gives `rsp_valid` in cycle t+1. `rsp_hit` is 1 when some valid entry in set `lk_pc[IDX_W-1:0]` holds the same full PC and its two source fields agree with `lk_src0`/`lk_src1`. `rsp_dst` is then that entry's destination tag, and the lowest-numbered matching way wins. A cycle with no lookup gives `rsp_valid` = 0.
- R2: A stored source field equal to the all-ones tag (the "no operand" code, 127 at the default width) agrees with any current source tag.
- R3: A lookup whose PC differs from every entry in its set, or whose source tag differs from a stored real source tag, misses (`rsp_hit` = 0).
- R4: A destination tag returned by one hit, used as a source tag of a dependent lookup, matches an entry filled with that tag as its source.
- R5: A fill goes to the lowest-numbered empty way of its set. In a full set it replaces the least recently used way, where both fills and hits count as use.
- R6: A fill that replaces a valid entry raises `free_valid` one cycle later with the displaced destination tag. The tag is held unchanged until `free_ready` is high.
- R7: When a valid entry is displaced, every entry in any set whose source field equals the freed tag stops matching from the next cycle on.
- R8: After `sq_valid` reports a PC, load lookups (`lk_is_load` = 1) at that PC miss from the next cycle on. Non-load lookups at that PC still hit.
- R9: The squash list holds BLK_N PCs and reuses its slots in rotation. The (BLK_N+1)-th report overwrites the oldest one, and loads at the overwritten PC can hit again.
- R10: `fill_ready` is 0 while `lk_valid` is 1 or while `free_valid` is 1 with `free_ready` 0, and 1 otherwise.
- R11: After reset no entry is valid, `rsp_valid` and `free_valid` are 0, and `fill_ready` and `lk_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready (always 1) |
| lk_pc | input | PC_W | PC of the instruction being renamed |
| lk_src0 | input | TAG_W | Current physical tag of source 0 |
| lk_src1 | input | TAG_W | Current physical tag of source 1 |
| lk_is_load | input | 1 | Instruction is a load |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Reuse granted |
| rsp_dst | output | TAG_W | Tag to map as destination (all ones on a miss) |
| fill_valid | input | 1 | Helper fill valid |
| fill_ready | output | 1 | Helper fill accepted |
| fill_pc | input | PC_W | PC of the helper instruction |
| fill_src0 | input | TAG_W | Source 0 tag read by the helper (all ones = none) |
| fill_src1 | input | TAG_W | Source 1 tag read by the helper (all ones = none) |
| fill_dst | input | TAG_W | Helper-owned destination tag |
| sq_valid | input | 1 | A reused load caused a squash |
| sq_pc | input | PC_W | PC of that load |
| free_valid | output | 1 | Freed tag valid |
| free_ready | input | 1 | Freed tag accepted |
| free_tag | output | TAG_W | Helper register tag to return to the free list |

## Verification
Directed lookups try a full match, a match through the no-operand code, a wrong PC in the same set, and a wrong source tag. These separate a real tag comparison from a PC-only or a value-blind one. A chain of two lookups that passes the first result into the second shows that reuse chains. A full set touched by a hit, then refilled, tells true LRU apart from fill order. A helper entry that reads a displaced register shows the cross-set invalidation. Load and non-load lookups at a squashed PC, before and after the list wraps, isolate the load filter. Seeded random mixes of fills, lookups and squashes over a few crowded sets then compare every response and every freed tag against a bench model.

// File: rtl/reuse_pkg.sv
package reuse_pkg;
  localparam int PC_W  = 16;
  localparam int TAG_W = 7;
  localparam logic [TAG_W-1:0] TAG_NONE = '1;

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [TAG_W-1:0] src0;
    logic [TAG_W-1:0] src1;
    logic [TAG_W-1:0] dst;
  } rt_entry_t;

  // A stored "no operand" field agrees with whatever the renamer holds.
  function automatic logic src_ok(input logic [TAG_W-1:0] stored,
                                  input logic [TAG_W-1:0] cur);
    return (stored == TAG_NONE) || (stored == cur);
  endfunction
endpackage

// File: rtl/rt_way_match.sv
module rt_way_match
  import reuse_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  rt_entry_t [WAYS-1:0]         ents,
  input  logic [WAYS-1:0]              vld,
  input  logic [PC_W-1:0]              q_pc,
  input  logic [TAG_W-1:0]             q_src0,
  input  logic [TAG_W-1:0]             q_src1,
  output logic                         hit,
  output logic [$clog2(WAYS)-1:0]      hit_way,
  output logic [TAG_W-1:0]             hit_dst
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAYS-1:0] way_hit;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_cmp
      assign way_hit[g] = vld[g]
                        && (ents[g].pc == q_pc)
                        && src_ok(ents[g].src0, q_src0)
                        && src_ok(ents[g].src1, q_src1);
    end
  endgenerate

  // Lowest-numbered matching way has priority.
  always_comb begin
    hit     = |way_hit;
    hit_way = '0;
    hit_dst = TAG_NONE;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (way_hit[i]) begin
        hit_way = WAY_W'(i);
        hit_dst = ents[i].dst;
      end
    end
  end
endmodule

// File: rtl/rt_age_touch.sv
module rt_age_touch #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0][$clog2(WAYS)-1:0] age_in,
  input  logic [$clog2(WAYS)-1:0]           touch,
  output logic [WAYS-1:0][$clog2(WAYS)-1:0] age_out
);
  localparam int WAY_W = $clog2(WAYS);

  logic [WAY_W-1:0] ref_age;

  // Ages form a permutation of 0..WAYS-1; 0 is most recent.
  always_comb begin
    ref_age = age_in[touch];
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) == touch)
        age_out[i] = '0;
      else if (age_in[i] < ref_age)
        age_out[i] = age_in[i] + 1'b1;
      else
        age_out[i] = age_in[i];
    end
  end
endmodule

// File: rtl/rt_block_list.sv
module rt_block_list
  import reuse_pkg::*;
#(
  parameter int BLK_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            add_en,
  input  logic [PC_W-1:0] add_pc,
  input  logic [PC_W-1:0] q_pc,
  output logic            q_blocked
);
  localparam int PTR_W = (BLK_N > 1) ? $clog2(BLK_N) : 1;

  logic [PC_W-1:0]  pcs_q [BLK_N];
  logic [BLK_N-1:0] used_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BLK_N-1:0] slot_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      ptr_q  <= '0;
    end else if (add_en) begin
      used_q[ptr_q] <= 1'b1;
      ptr_q <= (ptr_q == PTR_W'(BLK_N - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (add_en) pcs_q[ptr_q] <= add_pc;
  end

  genvar g;
  generate
    for (g = 0; g < BLK_N; g++) begin : g_slot
      assign slot_hit[g] = used_q[g] && (pcs_q[g] == q_pc);
    end
  endgenerate

  assign q_blocked = |slot_hit;
endmodule

// File: rtl/reuse_table.sv
module reuse_table
  import reuse_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int BLK_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [TAG_W-1:0] lk_src0,
  input  logic [TAG_W-1:0] lk_src1,
  input  logic             lk_is_load,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [TAG_W-1:0] rsp_dst,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [PC_W-1:0]  fill_pc,
  input  logic [TAG_W-1:0] fill_src0,
  input  logic [TAG_W-1:0] fill_src1,
  input  logic [TAG_W-1:0] fill_dst,
  input  logic             sq_valid,
  input  logic [PC_W-1:0]  sq_pc,
  output logic             free_valid,
  input  logic             free_ready,
  output logic [TAG_W-1:0] free_tag
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);

  typedef logic [WAYS-1:0][WAY_W-1:0] ages_t;

  rt_entry_t [WAYS-1:0] ent_q [SETS];
  logic [WAYS-1:0]      vld_q [SETS];
  ages_t                age_q [SETS];

  // ---------------- lookup path ----------------
  logic [IDX_W-1:0] lk_idx;
  logic             m_hit;
  logic [WAY_W-1:0] m_way;
  logic [TAG_W-1:0] m_dst;
  logic             blk_hit;
  logic             lk_grant;
  ages_t            lk_age_new;

  assign lk_ready = 1'b1;
  assign lk_idx   = lk_pc[IDX_W-1:0];

  rt_way_match #(.WAYS(WAYS)) u_match (
    .ents    (ent_q[lk_idx]),
    .vld     (vld_q[lk_idx]),
    .q_pc    (lk_pc),
    .q_src0  (lk_src0),
    .q_src1  (lk_src1),
    .hit     (m_hit),
    .hit_way (m_way),
    .hit_dst (m_dst)
  );

  rt_block_list #(.BLK_N(BLK_N)) u_blk (
    .clk       (clk),
    .rst_n     (rst_n),
    .add_en    (sq_valid),
    .add_pc    (sq_pc),
    .q_pc      (lk_pc),
    .q_blocked (blk_hit)
  );

  assign lk_grant = lk_valid && m_hit && !(lk_is_load && blk_hit);

  rt_age_touch #(.WAYS(WAYS)) u_age_lk (
    .age_in  (age_q[lk_idx]),
    .touch   (m_way),
    .age_out (lk_age_new)
  );

  // ---------------- fill path ----------------
  logic [IDX_W-1:0] fl_idx;
  logic             fill_fire;
  logic             free_stall;
  logic [WAY_W-1:0] victim;
  logic             vic_live;
  logic [TAG_W-1:0] vic_dst;
  logic [WAYS-1:0]  fl_vld;
  ages_t            fl_age;
  ages_t            fl_age_new;
  rt_entry_t        new_ent;

  assign fl_idx     = fill_pc[IDX_W-1:0];
  assign free_stall = free_valid && !free_ready;
  assign fill_ready = !lk_valid && !free_stall;
  assign fill_fire  = fill_valid && fill_ready;
  assign fl_vld     = vld_q[fl_idx];
  assign fl_age     = age_q[fl_idx];

  // Empty way first (lowest index), otherwise the oldest way.
  always_comb begin
    logic found;
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !fl_vld[i]) begin
        victim = WAY_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (fl_age[i] == WAY_W'(WAYS - 1)) victim = WAY_W'(i);
      end
    end
    vic_live = !found;
  end

  assign vic_dst = ent_q[fl_idx][victim].dst;

  rt_age_touch #(.WAYS(WAYS)) u_age_fl (
    .age_in  (fl_age),
    .touch   (victim),
    .age_out (fl_age_new)
  );

  always_comb begin
    new_ent.pc   = fill_pc;
    new_ent.src0 = fill_src0;
    new_ent.src1 = fill_src1;
    new_ent.dst  = fill_dst;
  end

  // Consumers of the register being freed, across every set.
  logic [WAYS-1:0] kill [SETS];
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        kill[s][w] = vld_q[s][w]
                   && ((ent_q[s][w].src0 == vic_dst) || (ent_q[s][w].src1 == vic_dst));
      end
    end
  end

  // ---------------- state ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
      end
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_dst    <= TAG_NONE;
      free_valid <= 1'b0;
      free_tag   <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_grant;
      rsp_dst   <= lk_grant ? m_dst : TAG_NONE;

      if (lk_grant) age_q[lk_idx] <= lk_age_new;

      if (free_valid && free_ready) free_valid <= 1'b0;

      if (fill_fire) begin
        if (vic_live) begin
          for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
              if (kill[s][w]) vld_q[s][w] <= 1'b0;
            end
          end
          free_valid <= 1'b1;
          free_tag   <= vic_dst;
        end
        vld_q[fl_idx][victim] <= 1'b1;
        age_q[fl_idx]         <= fl_age_new;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire) ent_q[fl_idx][victim] <= new_ent;
  end
endmodule

// File: rtl/reuse_table_chk.sv
module reuse_table_chk
  import reuse_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int BLK_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [PC_W-1:0]  lk_pc,
  input logic             lk_is_load,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [TAG_W-1:0] rsp_dst,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic             sq_valid,
  input logic [PC_W-1:0]  sq_pc,
  input logic             free_valid,
  input logic             free_ready,
  input logic [TAG_W-1:0] free_tag
);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);

  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);

  p_hit_tag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && (rsp_dst != TAG_NONE));

  p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid || (free_valid && !free_ready)) |-> !fill_ready);

  p_free_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && !free_ready |=> free_valid && $stable(free_tag));

  p_free_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid |-> free_tag != TAG_NONE);

  p_free_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(free_valid) |-> $past(fill_valid && fill_ready));

  p_load_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_is_load && $past(sq_valid) && (lk_pc == $past(sq_pc)) |=> !rsp_hit);
endmodule

bind reuse_table reuse_table_chk #(.SETS(SETS), .WAYS(WAYS), .BLK_N(BLK_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_ready   (lk_ready),
  .lk_pc      (lk_pc),
  .lk_is_load (lk_is_load),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_dst    (rsp_dst),
  .fill_valid (fill_valid),
  .fill_ready (fill_ready),
  .sq_valid   (sq_valid),
  .sq_pc      (sq_pc),
  .free_valid (free_valid),
  .free_ready (free_ready),
  .free_tag   (free_tag)
);

// File: tb/reuse_table_bench.sv
module reuse_table_bench;
  import reuse_pkg::*;

  localparam int SETS  = 16;
  localparam int WAYS  = 4;
  localparam int BLK_N = 4;
  localparam logic [TAG_W-1:0] NO = TAG_NONE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0, lk_is_load = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic [TAG_W-1:0] lk_src0 = '0, lk_src1 = '0;
  logic fill_valid = 1'b0;
  logic [PC_W-1:0] fill_pc = '0;
  logic [TAG_W-1:0] fill_src0 = '0, fill_src1 = '0, fill_dst = '0;
  logic sq_valid = 1'b0;
  logic [PC_W-1:0] sq_pc = '0;
  logic free_ready = 1'b1;
  logic lk_ready, rsp_valid, rsp_hit, fill_ready, free_valid;
  logic [TAG_W-1:0] rsp_dst, free_tag;

  always #4 clk = ~clk;

  reuse_table #(.SETS(SETS), .WAYS(WAYS), .BLK_N(BLK_N)) u_reuse_table (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .lk_src0(lk_src0), .lk_src1(lk_src1), .lk_is_load(lk_is_load),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dst(rsp_dst),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_pc(fill_pc),
    .fill_src0(fill_src0), .fill_src1(fill_src1), .fill_dst(fill_dst),
    .sq_valid(sq_valid), .sq_pc(sq_pc),
    .free_valid(free_valid), .free_ready(free_ready), .free_tag(free_tag)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all-reqs actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- reference model ----------------
  bit m_v [SETS][WAYS];
  int m_pc [SETS][WAYS], m_s0 [SETS][WAYS], m_s1 [SETS][WAYS], m_d [SETS][WAYS];
  int m_age [SETS][WAYS];
  int b_pc [BLK_N];
  bit b_v [BLK_N];
  int b_ptr = 0;

  function automatic bit agree(input int stored, input int cur);
    return (stored == int'(NO)) || (stored == cur);
  endfunction

  function automatic int m_find(input int pc, input int s0, input int s1);
    int st = pc % SETS;
    for (int w = 0; w < WAYS; w++)
      if (m_v[st][w] && m_pc[st][w] == pc && agree(m_s0[st][w], s0) && agree(m_s1[st][w], s1))
        return w;
    return -1;
  endfunction

  function automatic bit m_blocked(input int pc);
    for (int i = 0; i < BLK_N; i++) if (b_v[i] && b_pc[i] == pc) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_touch(input int st, input int w);
    int ref_a = m_age[st][w];
    for (int i = 0; i < WAYS; i++)
      if (i == w) m_age[st][i] = 0;
      else if (m_age[st][i] < ref_a) m_age[st][i]++;
  endtask

  task automatic m_fill(input int pc, input int s0, input int s1, input int d,
                        output bit ev, output int evd);
    int st = pc % SETS;
    int vw = -1;
    for (int w = 0; w < WAYS; w++) if (vw < 0 && !m_v[st][w]) vw = w;
    ev = (vw < 0);
    evd = 0;
    if (ev) begin
      for (int w = 0; w < WAYS; w++) if (m_age[st][w] == WAYS - 1) vw = w;
      evd = m_d[st][vw];
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (m_v[s][w] && (m_s0[s][w] == evd || m_s1[s][w] == evd)) m_v[s][w] = 1'b0;
    end
    m_v[st][vw] = 1'b1;
    m_pc[st][vw] = pc; m_s0[st][vw] = s0; m_s1[st][vw] = s1; m_d[st][vw] = d;
    m_touch(st, vw);
  endtask

  // ---------------- stimulus tasks ----------------
  task automatic do_lookup(input int pc, input int s0, input int s1, input bit ld,
                           input string req);
    int w;
    bit eh;
    int ed;
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PC_W'(pc); lk_src0 = TAG_W'(s0); lk_src1 = TAG_W'(s1);
    lk_is_load = ld;
    w = m_find(pc, s0, s1);
    eh = (w >= 0) && !(ld && m_blocked(pc));
    ed = eh ? m_d[pc % SETS][w] : int'(NO);
    if (eh) m_touch(pc % SETS, w);
    @(negedge clk);
    lk_valid = 1'b0;
    check({req, " rsp_valid"}, int'(rsp_valid), 1);
    check({req, " hit"}, int'(rsp_hit), int'(eh));
    if (eh) check({req, " dst"}, int'(rsp_dst), ed);
  endtask

  task automatic do_fill(input int pc, input int s0, input int s1, input int d,
                         input string req);
    bit ev;
    int evd;
    @(negedge clk);
    fill_valid = 1'b1; fill_pc = PC_W'(pc);
    fill_src0 = TAG_W'(s0); fill_src1 = TAG_W'(s1); fill_dst = TAG_W'(d);
    while (!fill_ready) @(negedge clk);
    m_fill(pc, s0, s1, d, ev, evd);
    @(negedge clk);
    fill_valid = 1'b0;
    check({req, " free_valid"}, int'(free_valid), int'(ev));
    if (ev) check({req, " free_tag"}, int'(free_tag), evd);
  endtask

  task automatic do_squash(input int pc);
    @(negedge clk);
    sq_valid = 1'b1; sq_pc = PC_W'(pc);
    b_pc[b_ptr] = pc; b_v[b_ptr] = 1'b1; b_ptr = (b_ptr + 1) % BLK_N;
    @(negedge clk);
    sq_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_v[s][w] = 1'b0; m_age[s][w] = w; end
    for (int i = 0; i < BLK_N; i++) b_v[i] = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 rsp_valid", int'(rsp_valid), 0);
    check("R11 free_valid", int'(free_valid), 0);
    check("R11 fill_ready", int'(fill_ready), 1);
    check("R11 lk_ready", int'(lk_ready), 1);
    do_lookup(16'h0005, 1, 2, 0, "R11 empty-table miss");

    // R1: plain hit, dst 20
    do_fill(16'h0010, 3, 4, 20, "R5 fill");
    do_lookup(16'h0010, 3, 4, 0, "R1 full match");
    check("R1 dst value", int'(rsp_dst), 20);
    // R3: wrong source tag, wrong PC in same set
    do_lookup(16'h0010, 3, 5, 0, "R3 src mismatch");
    do_lookup(16'h0020, 3, 4, 0, "R3 pc mismatch");
    // R2: no-operand field
    do_fill(16'h0011, 3, int'(NO), 21, "R5 fill");
    do_lookup(16'h0011, 3, 9, 0, "R2 none field");
    check("R2 dst value", int'(rsp_dst), 21);
    // R4: chaining through returned tag
    do_fill(16'h0012, 21, int'(NO), 22, "R5 fill");
    do_lookup(16'h0011, 3, 9, 0, "R4 head");
    do_lookup(16'h0012, int'(rsp_dst), 0, 0, "R4 chained");
    check("R4 chained dst", int'(rsp_dst), 22);

    // R5/R6: LRU in set 5, hit on way 0 makes 0x15 the victim (dst 41)
    do_fill(16'h0005, 1, 2, 40, "R5 fill");
    do_fill(16'h0015, 1, 2, 41, "R5 fill");
    do_fill(16'h0025, 1, 2, 42, "R5 fill");
    do_fill(16'h0035, 1, 2, 43, "R5 fill");
    do_lookup(16'h0005, 1, 2, 0, "R5 touch");
    do_fill(16'h0045, 1, 2, 44, "R6 evict lru");
    check("R6 freed tag 41", int'(free_tag), 41);
    do_lookup(16'h0015, 1, 2, 0, "R5 evicted gone");
    do_lookup(16'h0005, 1, 2, 0, "R5 kept");

    // R7: consumer of a freed tag stops matching
    do_fill(16'h0006, 1, int'(NO), 50, "R7 fill");
    do_fill(16'h0016, 50, int'(NO), 51, "R7 fill");
    do_fill(16'h0026, 1, 2, 52, "R7 fill");
    do_fill(16'h0036, 1, 2, 53, "R7 fill");
    do_fill(16'h0046, 1, 2, 54, "R7 evict producer");
    check("R7 freed tag 50", int'(free_tag), 50);
    do_lookup(16'h0016, 50, 0, 0, "R7 consumer dropped");
    check("R7 consumer miss", int'(rsp_hit), 0);

    // R6/R10: free stream stalled
    free_ready = 1'b0;
    do_fill(16'h0055, 1, 2, 45, "R6 stalled evict");
    check("R6 stalled tag 42", int'(free_tag), 42);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 hold valid", int'(free_valid), 1);
      check("R6 hold tag", int'(free_tag), 42);
      check("R10 fill held", int'(fill_ready), 0);
    end
    free_ready = 1'b1;
    @(negedge clk);
    check("R6 drained", int'(free_valid), 0);
    check("R10 fill open", int'(fill_ready), 1);
    lk_valid = 1'b1; lk_pc = 16'h0001;
    #1 check("R10 lookup blocks fill", int'(fill_ready), 0);
    lk_valid = 1'b0;
    #1 check("R10 fill open again", int'(fill_ready), 1);

    // R8: squash filter
    do_squash(16'h0010);
    do_lookup(16'h0010, 3, 4, 1, "R8 load blocked");
    check("R8 load miss", int'(rsp_hit), 0);
    do_lookup(16'h0010, 3, 4, 0, "R8 non-load hits");
    check("R8 non-load hit", int'(rsp_hit), 1);
    // R9: wrap overwrites oldest (0x10)
    do_squash(16'h0030); do_squash(16'h0031); do_squash(16'h0032);
    do_lookup(16'h0010, 3, 4, 1, "R9 still blocked");
    do_squash(16'h0033);
    do_lookup(16'h0010, 3, 4, 1, "R9 unblocked after wrap");
    check("R9 load hit", int'(rsp_hit), 1);

    // Random mix over crowded sets
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 10;
      int pc = $urandom % 64;
      if (r < 4) begin
        int s1 = ($urandom % 3 == 0) ? int'(NO) : int'($urandom % 4);
        do_fill(pc, $urandom % 4, s1, $urandom % 8, "R5 R6 R7 random fill");
      end else if (r < 9) begin
        do_lookup(pc, $urandom % 4, $urandom % 4, 1'($urandom % 2), "R1 R2 R3 R8 random lookup");
      end else begin
        do_squash(pc);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule